// File: doc/BRIEF.md
# Automatic Line Activation Controller

This block picks the operating state of a subscriber line on its own once the host has written an active mode word. It keeps the line in a low-power high-impedance feed while the loop is idle. A detected off-hook moves it to a stand-by state where the event is confirmed. Only a confirmed off-hook reaches the full active state. On the way back, a timed window keeps the line active through the short breaks of pulse dialling. The host also uses the same three-bit word to select power-down, ringing and on-hook transmission.

The controller runs on a free-running internal clock. It measures time by counting falling edges of an external ring clock, which it first synchronises. The analog loop detectors are outside the block: their results arrive as flags. One flag is valid only in high-impedance feed. The other is valid in stand-by, active and on-hook transmission. The block drives the active-low off-hook indicator, the active-low alarm indicator, the polarity select and the ringing relay command.

Top module: `line_autoact`

## Requirements
- R1: After the synchronous reset, or while `line_rst_n` is low, the next state is power-down (`line_state` = 0). `det_n` and `alarm_n` are high and `ring_relay` is low when no fault input is set.
- R2: A change of `mode_word` takes effect on the next clock edge and overrides any timed state. 000 enters power-down (0), 001 enters ringing (1), 010 and 011 enter on-hook transmission (2), and 100, 101, 110 and 111 enter high-impedance feed (3).
- R3: In high-impedance feed, `hz_offhook` moves the state to stand-by (4) on the next edge. `sb_offhook` has no effect in this state.
- R4: In stand-by, `sb_offhook` moves the state to active (5) on the next edge. If no off-hook arrives within `RING_PERIODS` (128) synchronised falling edges of `ring_clk`, the state returns to high-impedance feed.
- R5: In active, `det_n` is low one edge after `sb_offhook` is high, and it is high again one edge after the flag drops.
- R6: After `sb_offhook` drops in active, the state holds for `RING_PERIODS` ring-clock falls. Any off-hook within that window restarts the count. At expiry the state returns to high-impedance feed, but only when `mode_word` is 100; with any other word the state stays active.
- R7: `rev_pol` is high only in active with word 111, and in on-hook transmission with word 010. It is low in every other case, including high-impedance feed and stand-by.
- R8: In on-hook transmission, `sb_offhook` moves the state to active on the next edge.
- R9: In ringing, `ring_relay` turns on only once the synchronised `ring_clk` is low, and then stays on. `ring_trip` turns the relay off on the next edge and latches `det_n` low until `mode_word` changes.
- R10: `thermal_alarm` or `gnd_key` drives both `det_n` and `alarm_n` low on the next edge, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| line_rst_n | input | 1 | Host reset, active low, forces power-down |
| mode_word | input | 3 | Host mode word, bit 2 is the leading digit |
| ring_clk | input | 1 | External ring clock, asynchronous |
| hz_offhook | input | 1 | Off-hook flag of the high-impedance detector |
| sb_offhook | input | 1 | Off-hook flag of the stand-by/active detector |
| ring_trip | input | 1 | Ring-trip detector flag |
| thermal_alarm | input | 1 | Thermal overload flag |
| gnd_key | input | 1 | Ground-key flag |
| line_state | output | 3 | Current state: 0 pdown, 1 ring, 2 oht, 3 hz, 4 sby, 5 act |
| rev_pol | output | 1 | Reverse polarity select |
| det_n | output | 1 | Off-hook / ring-trip indicator, active low |
| alarm_n | output | 1 | Alarm indicator, active low |
| ring_relay | output | 1 | Ringing relay command |

## Verification
Random mode words with all flags quiet show that each word decodes to the right entry state and polarity. They also show that an unchanged word leaves that state alone. A directed walk takes the line through high-impedance feed, stand-by and active with the ring clock running, and times the stand-by timeout and the on-hook hold window. Checks on both sides of the 128-period limit separate a correct window from one that is too short or too long. A short off-hook pulse inside the window tells a window that restarts from one that does not. Repeating the hold with word 111 tells the word-gated fallback from an unconditional one. A hand-driven ring clock isolates the relay's wait for the low level from the trip latch.

// File: rtl/lac_pkg.sv
package lac_pkg;

  typedef enum logic [2:0] {
    ST_PDOWN = 3'd0,
    ST_RING  = 3'd1,
    ST_OHT   = 3'd2,
    ST_HZ    = 3'd3,
    ST_SBY   = 3'd4,
    ST_ACT   = 3'd5
  } lstate_t;

  localparam int WORD_W = 3;

  localparam logic [WORD_W-1:0] WORD_DEFAULT = 3'b100;
  localparam logic [WORD_W-1:0] WORD_ACT_REV = 3'b111;
  localparam logic [WORD_W-1:0] WORD_OHT_REV = 3'b010;

  // State entered when the host writes a new word.
  function automatic lstate_t word_entry(input logic [WORD_W-1:0] w);
    lstate_t s;
    if (w[2])           s = ST_HZ;
    else if (w[1])      s = ST_OHT;
    else if (w[0])      s = ST_RING;
    else                s = ST_PDOWN;
    return s;
  endfunction

endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_async,
  output logic ring_low,
  output logic ring_fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= ring_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[LAST];
  end

  assign ring_low  = ~chain[LAST];
  assign ring_fall = prev & ~chain[LAST];

endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)            cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

endmodule

// File: rtl/line_fsm.sv
module line_fsm
  import lac_pkg::*;
(
  input  lstate_t           state,
  input  logic [WORD_W-1:0] mode_word,
  input  logic              word_chg,
  input  logic              line_rst_n,
  input  logic              hz_offhook,
  input  logic              sb_offhook,
  input  logic              expired,
  output lstate_t           nxt,
  output logic              tmr_clear
);

  always_comb begin
    nxt = state;
    if (!line_rst_n) begin
      nxt = ST_PDOWN;
    end else if (word_chg) begin
      nxt = word_entry(mode_word);
    end else begin
      case (state)
        ST_HZ:   if (hz_offhook) nxt = ST_SBY;
        ST_SBY:  begin
          if (sb_offhook)   nxt = ST_ACT;
          else if (expired) nxt = ST_HZ;
        end
        ST_ACT:  if (!sb_offhook && expired && mode_word == WORD_DEFAULT)
                   nxt = ST_HZ;
        ST_OHT:  if (sb_offhook) nxt = ST_ACT;
        default: nxt = state;
      endcase
    end
  end

  // Timer runs only in stand-by and in active while on-hook.
  always_comb begin
    tmr_clear = (nxt != state)
             || !(state == ST_SBY || state == ST_ACT)
             || (state == ST_ACT && sb_offhook);
  end

endmodule

// File: rtl/line_autoact.sv
module line_autoact
  import lac_pkg::*;
#(
  parameter int RING_PERIODS = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_rst_n,
  input  logic [2:0] mode_word,
  input  logic       ring_clk,
  input  logic       hz_offhook,
  input  logic       sb_offhook,
  input  logic       ring_trip,
  input  logic       thermal_alarm,
  input  logic       gnd_key,
  output logic [2:0] line_state,
  output logic       rev_pol,
  output logic       det_n,
  output logic       alarm_n,
  output logic       ring_relay
);

  lstate_t           state, nxt;
  logic [WORD_W-1:0] word_q;
  logic              word_chg;
  logic              ring_low, ring_fall;
  logic              expired, tmr_clear;
  logic              trip_q, trip_nxt;
  logic              fault;

  ring_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .ring_async (ring_clk),
    .ring_low   (ring_low),
    .ring_fall  (ring_fall)
  );

  period_timer #(.LIMIT(RING_PERIODS)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .tick    (ring_fall),
    .expired (expired)
  );

  line_fsm u_fsm (
    .state      (state),
    .mode_word  (mode_word),
    .word_chg   (word_chg),
    .line_rst_n (line_rst_n),
    .hz_offhook (hz_offhook),
    .sb_offhook (sb_offhook),
    .expired    (expired),
    .nxt        (nxt),
    .tmr_clear  (tmr_clear)
  );

  assign word_chg = (mode_word != word_q);
  assign fault    = thermal_alarm | gnd_key;
  assign trip_nxt = (nxt == ST_RING) & (trip_q | (state == ST_RING & ring_trip));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PDOWN;
      word_q     <= '0;
      trip_q     <= 1'b0;
      ring_relay <= 1'b0;
      det_n      <= 1'b1;
      alarm_n    <= 1'b1;
      rev_pol    <= 1'b0;
    end else begin
      state      <= nxt;
      word_q     <= line_rst_n ? mode_word : '0;
      trip_q     <= trip_nxt;
      ring_relay <= (nxt == ST_RING) & ~thermal_alarm & ~trip_nxt
                    & (ring_relay | ring_low);
      det_n      <= ~(fault | (state == ST_ACT & sb_offhook) | trip_nxt);
      alarm_n    <= ~fault;
      rev_pol    <= (nxt == ST_ACT & mode_word == WORD_ACT_REV)
                  | (nxt == ST_OHT & mode_word == WORD_OHT_REV);
    end
  end

  assign line_state = state;

endmodule

// File: rtl/lac_chk.sv
module lac_chk
  import lac_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       line_rst_n,
  input logic [2:0] mode_word,
  input logic [2:0] word_q,
  input logic       hz_offhook,
  input logic       sb_offhook,
  input logic       thermal_alarm,
  input logic       gnd_key,
  input logic [2:0] line_state,
  input logic       rev_pol,
  input logic       det_n,
  input logic       alarm_n,
  input logic       ring_relay
);

  logic same_word;
  assign same_word = (mode_word == word_q) && line_rst_n;

  // R1
  hold_pdown_chk: assert property (@(posedge clk) disable iff (rst)
    !line_rst_n |=> line_state == 3'd0);

  // R3
  hz_to_sby_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd3 && hz_offhook && same_word) |=> line_state == 3'd4);

  // R4
  sby_confirm_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd4 && sb_offhook && same_word) |=> line_state == 3'd5);

  // R5
  det_release_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd5 && !sb_offhook && !thermal_alarm && !gnd_key) |=> det_n);

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd5 && same_word && mode_word != 3'b100) |=> line_state == 3'd5);

  // R7
  hz_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd3 || line_state == 3'd4) |-> !rev_pol);

  // R9
  relay_scope_chk: assert property (@(posedge clk) disable iff (rst)
    ring_relay |-> line_state == 3'd1);

  // R10
  fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (thermal_alarm || gnd_key) |=> (!alarm_n && !det_n));

endmodule

bind line_autoact lac_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .line_rst_n    (line_rst_n),
  .mode_word     (mode_word),
  .word_q        (word_q),
  .hz_offhook    (hz_offhook),
  .sb_offhook    (sb_offhook),
  .thermal_alarm (thermal_alarm),
  .gnd_key       (gnd_key),
  .line_state    (line_state),
  .rev_pol       (rev_pol),
  .det_n         (det_n),
  .alarm_n       (alarm_n),
  .ring_relay    (ring_relay)
);

// File: tb/line_autoact_bench.sv
`timescale 1ns/1ps
module line_autoact_bench;

  localparam int RHALF = 10;
  localparam int RPER  = 2 * RHALF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_rst_n = 1'b1;
  logic [2:0] mode_word = 3'b000;
  logic       ring_gen = 1'b1;
  logic       ring_man = 1'b1;
  logic       ring_run = 1'b0;
  logic       ring_clk;
  logic       hz_offhook = 1'b0;
  logic       sb_offhook = 1'b0;
  logic       ring_trip = 1'b0;
  logic       thermal_alarm = 1'b0;
  logic       gnd_key = 1'b0;
  logic [2:0] line_state;
  logic       rev_pol, det_n, alarm_n, ring_relay;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  assign ring_clk = ring_run ? ring_gen : ring_man;

  initial begin
    forever begin
      repeat (RHALF) @(negedge clk);
      ring_gen = ~ring_gen;
    end
  end

  line_autoact u_line_autoact (
    .clk(clk), .rst(rst), .line_rst_n(line_rst_n), .mode_word(mode_word),
    .ring_clk(ring_clk), .hz_offhook(hz_offhook), .sb_offhook(sb_offhook),
    .ring_trip(ring_trip), .thermal_alarm(thermal_alarm), .gnd_key(gnd_key),
    .line_state(line_state), .rev_pol(rev_pol), .det_n(det_n),
    .alarm_n(alarm_n), .ring_relay(ring_relay)
  );

  function automatic int exp_entry(input logic [2:0] w);
    if (w[2])      return 3;
    else if (w[1]) return 2;
    else if (w[0]) return 1;
    return 0;
  endfunction

  function automatic int exp_entry_pol(input logic [2:0] w);
    return (w == 3'b010) ? 1 : 0;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 state", line_state, 0);
    chk("R1 det_n", det_n, 1);
    chk("R1 alarm_n", alarm_n, 1);
    chk("R1 relay", ring_relay, 0);

    // R2 random words, flags quiet
    for (int i = 0; i < 40; i++) begin
      logic [2:0] w;
      w = 3'($urandom(32'd7 + 32'(i)));
      mode_word = w;
      step(1);
      chk("R2 entry", line_state, exp_entry(w));
      chk("R7 entry pol", rev_pol, exp_entry_pol(w));
      step(3);
      chk("R2 stable", line_state, exp_entry(w));
    end

    // R9 ringing with hand-driven ring clock
    mode_word = 3'b000; step(2);
    ring_man = 1'b1;
    mode_word = 3'b001; step(6);
    chk("R9 relay waits", ring_relay, 0);
    ring_man = 1'b0; step(4);
    chk("R9 relay on", ring_relay, 1);
    ring_man = 1'b1; step(6);
    chk("R9 relay held", ring_relay, 1);
    ring_trip = 1'b1; step(1);
    ring_trip = 1'b0;
    chk("R9 relay off", ring_relay, 0);
    chk("R9 det latched", det_n, 0);
    step(10);
    chk("R9 det still low", det_n, 0);
    mode_word = 3'b000; step(2);
    chk("R9 det cleared", det_n, 1);

    // R4 stand-by timeout
    ring_run = 1'b1;
    mode_word = 3'b100; step(1);
    chk("R2 hz", line_state, 3);
    sb_offhook = 1'b1; step(4);
    chk("R3 sb ignored", line_state, 3);
    chk("R3 det quiet", det_n, 1);
    sb_offhook = 1'b0;
    hz_offhook = 1'b1; step(1);
    hz_offhook = 1'b0;
    chk("R3 to sby", line_state, 4);
    chk("R7 sby pol", rev_pol, 0);
    step(120 * RPER);
    chk("R4 sby before limit", line_state, 4);
    step(16 * RPER);
    chk("R4 sby timeout", line_state, 3);

    // R4/R5/R6 confirm and hold
    hz_offhook = 1'b1; step(1);
    hz_offhook = 1'b0;
    step(40);
    sb_offhook = 1'b1; step(1);
    chk("R4 to act", line_state, 5);
    step(1);
    chk("R5 det low", det_n, 0);
    sb_offhook = 1'b0; step(1);
    chk("R5 det high", det_n, 1);
    chk("R6 act held", line_state, 5);
    step(60 * RPER);
    sb_offhook = 1'b1; step(5);
    chk("R6 pulse det", det_n, 0);
    sb_offhook = 1'b0;
    step(120 * RPER);
    chk("R6 restart held", line_state, 5);
    step(16 * RPER);
    chk("R6 fallback", line_state, 3);

    // R6/R7 word 111 blocks fallback
    mode_word = 3'b111; step(1);
    chk("R7 hz direct", rev_pol, 0);
    hz_offhook = 1'b1; step(1);
    hz_offhook = 1'b0;
    sb_offhook = 1'b1; step(1);
    chk("R7 act state", line_state, 5);
    chk("R7 act reverse", rev_pol, 1);
    sb_offhook = 1'b0;
    step(140 * RPER);
    chk("R6 no fallback", line_state, 5);

    // R8 on-hook transmission
    mode_word = 3'b010; step(1);
    chk("R2 oht", line_state, 2);
    chk("R7 oht reverse", rev_pol, 1);
    mode_word = 3'b011; step(1);
    chk("R7 oht direct", rev_pol, 0);
    sb_offhook = 1'b1; step(1);
    chk("R8 oht to act", line_state, 5);
    chk("R7 act direct", rev_pol, 0);
    sb_offhook = 1'b0; step(2);

    // R10 faults
    thermal_alarm = 1'b1; step(1);
    chk("R10 thermal det", det_n, 0);
    chk("R10 thermal alarm", alarm_n, 0);
    thermal_alarm = 1'b0; step(1);
    chk("R10 clear", alarm_n, 1);
    gnd_key = 1'b1; step(1);
    chk("R10 gndkey det", det_n, 0);
    chk("R10 gndkey alarm", alarm_n, 0);
    gnd_key = 1'b0; step(1);

    // R1 host reset
    mode_word = 3'b100; step(2);
    line_rst_n = 1'b0; step(1);
    chk("R1 host reset", line_state, 0);
    step(3);
    chk("R1 held", line_state, 0);
    line_rst_n = 1'b1; step(2);
    chk("R1 release", line_state, 3);

    done = 1'b1;
    report();
    $finish;
  end

endmodule